// File: doc/BRIEF.md
# OTP Serial Command Sequencer

This block sends a short burst of byte commands to a one-time-programmable memory macro over a bit-serial link. Software sets it up through a small register port. It writes a target device address and the number of commands into control registers. It stages each command byte in a command buffer. Then it sets a single enable bit. The sequencer asserts chip select, shifts out the device address byte and then each staged command byte, most significant bit first, at one bit per clock. It then drops chip select and raises a sticky done flag that software clears by writing one to it.

An optional lead time holds chip select active for a programmable number of idle clocks before the first bit. This gives the macro set-up time. A common burst is a register write to the macro's error-correction control register: command byte 0xFA (0xC0 for the write opcode, ORed with register number 0x3A), followed by data byte 0x09 to turn correction off or 0x00 to turn it on. While a burst is running, the configuration cannot change.

Top module: `otp_cmd_seq`

## Requirements
- R1: Writes to the control (0x20), count (0x24) and lead (0x28) registers are masked. Bit n of the low half changes only when bit n+16 of the written value is 1. All other bits keep their old value.
- R2: In the control register, bits 15:8 hold the device address and bit 0 is the enable. A masked write that sets the enable while idle starts a burst.
- R3: The count register holds the number of command bytes minus one, stored in clog2(DEPTH) bits. The burst sends buffer entries 0 to count in order. Entry i is the low byte of the word at 0x1000 + 4*i.
- R4: Each burst is one continuous chip-select window. The device address byte is sent first, then the command bytes, each MSB first. One bit is sent per clock, with the strobe high on every data bit.
- R5: The lead register (LEAD_W bits) sets L. Chip select is high with the strobe low for exactly L clocks before the first data bit.
- R6: Once the last bit has been sent, bit 1 of the interrupt status register (0x304) becomes 1. It is visible 2+L+8*N clocks after the edge that sampled the enable write, where N is count+2.
- R7: Writing 1 to bit 1 of 0x304 clears the done flag. Writing 0 there leaves it unchanged.
- R8: The enable bit clears itself when the burst ends. Bit 0 of the status register (0x2C) reads 1 from the enable write until done is raised.
- R9: While busy, writes to the command buffer, control, count and lead registers are ignored. The interrupt status register still accepts writes.
- R10: After reset, all registers read zero and chip select and strobe are low. Reads are combinational from the address, and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| otp_cs | output | 1 | Chip select to the memory macro, active high |
| otp_stb | output | 1 | High when otp_dat carries a data bit |
| otp_dat | output | 1 | Serial data bit |

## Verification
A register write takes effect on the edge that samples it, and read data is valid in the same cycle as the address. The serial outputs lag the enable write by one edge: the first chip-select cycle, whether lead or data, follows the second edge. Done appears 2+L+8*N edges after the enable write. The bench builds the expected per-cycle output triple for the whole burst when the enable write is sampled. It compares one entry at every falling edge, and it reads done and busy back only after the end-of-burst cycle has been consumed.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

    localparam logic [15:0] OFF_CTRL = 16'h0020;
    localparam logic [15:0] OFF_CNT  = 16'h0024;
    localparam logic [15:0] OFF_LEAD = 16'h0028;
    localparam logic [15:0] OFF_STAT = 16'h002C;
    localparam logic [15:0] OFF_INT  = 16'h0304;
    localparam logic [15:0] OFF_BUF  = 16'h1000;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_FIN   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic cs;
        logic stb;
        logic dat;
    } ser_pins_t;

    // upper half of the written word selects which low-half bits change
    function automatic logic [15:0] mask_merge(input logic [15:0] cur,
                                               input logic [31:0] wv);
        return (cur & ~wv[31:16]) | (wv[15:0] & wv[31:16]);
    endfunction

endpackage

// File: rtl/otp_seq_regs.sv
module otp_seq_regs
    import otp_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 3,
    parameter int LEAD_W = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [31:0]            wdata,
    output logic [31:0]            rdata,
    input  logic                   seq_active,
    input  logic                   seq_fin,
    output logic                   ctrl_en,
    output logic [7:0]             dev_addr,
    output logic [CNT_W-1:0]       last_cnt,
    output logic [LEAD_W-1:0]      lead,
    output logic [DEPTH-1:0][7:0]  cmd_buf
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFF_CNT);
    localparam logic [ADDR_W-1:0] A_LEAD = ADDR_W'(OFF_LEAD);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_INT  = ADDR_W'(OFF_INT);
    localparam logic [ADDR_W-1:0] A_BUF  = ADDR_W'(OFF_BUF);

    logic [15:0]           ctrl_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [LEAD_W-1:0]     lead_q;
    logic [DEPTH-1:0][7:0] buf_q;
    logic                  done_q;
    logic                  busy;
    logic                  cfg_wr;
    logic [15:0]           cnt_next;
    logic [15:0]           lead_next;
    logic [ADDR_W-1:0]     buf_off;
    logic                  buf_hit;
    logic [CNT_W-1:0]      buf_sel;

    assign busy      = ctrl_q[0] | seq_active;
    assign cfg_wr    = wr_en & ~busy;
    assign cnt_next  = mask_merge(16'(cnt_q), wdata);
    assign lead_next = mask_merge(16'(lead_q), wdata);

    assign buf_off = addr - A_BUF;
    assign buf_hit = (addr >= A_BUF) && (buf_off[1:0] == 2'b00) &&
                     (buf_off[ADDR_W-1:2] < (ADDR_W-2)'(DEPTH));
    assign buf_sel = buf_off[CNT_W+1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (seq_fin) begin
            ctrl_q[0] <= 1'b0;
        end else if (cfg_wr && addr == A_CTRL) begin
            ctrl_q <= mask_merge(ctrl_q, wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            lead_q <= '0;
        end else begin
            if (cfg_wr && addr == A_CNT)  cnt_q  <= cnt_next[CNT_W-1:0];
            if (cfg_wr && addr == A_LEAD) lead_q <= lead_next[LEAD_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
        end else if (seq_fin) begin
            done_q <= 1'b1;
        end else if (wr_en && addr == A_INT && wdata[1]) begin
            done_q <= 1'b0;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_buf
        always_ff @(posedge clk) begin
            if (rst) begin
                buf_q[g] <= '0;
            end else if (cfg_wr && buf_hit && buf_sel == CNT_W'(g)) begin
                buf_q[g] <= wdata[7:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL)      rdata = {16'h0, ctrl_q};
        else if (addr == A_CNT)  rdata = 32'(cnt_q);
        else if (addr == A_LEAD) rdata = 32'(lead_q);
        else if (addr == A_STAT) rdata = {31'h0, busy};
        else if (addr == A_INT)  rdata = {30'h0, done_q, 1'b0};
        else if (buf_hit)        rdata = {24'h0, buf_q[buf_sel]};
    end

    assign ctrl_en  = ctrl_q[0];
    assign dev_addr = ctrl_q[15:8];
    assign last_cnt = cnt_q;
    assign lead     = lead_q;
    assign cmd_buf  = buf_q;

    p_done_set_r6: assert property (@(posedge clk) disable iff (rst)
        seq_fin |=> done_q);

    p_en_clear_r8: assert property (@(posedge clk) disable iff (rst)
        seq_fin |=> !ctrl_q[0]);

    p_buf_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(buf_q));

endmodule

// File: rtl/otp_seq_shifter.sv
module otp_seq_shifter
    import otp_seq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 3,
    parameter int LEAD_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [7:0]            dev_addr,
    input  logic [CNT_W-1:0]      last_cnt,
    input  logic [LEAD_W-1:0]     lead,
    input  logic [DEPTH-1:0][7:0] cmd_buf,
    output logic                  active,
    output logic                  fin,
    output ser_pins_t             pins
);

    localparam int IDX_W = CNT_W + 1;

    seq_state_e        state;
    logic [LEAD_W-1:0] lead_left;
    logic [2:0]        bit_left;
    logic [IDX_W-1:0]  byte_idx;
    logic [7:0]        shreg;
    logic [IDX_W-1:0]  last_idx;

    assign last_idx = IDX_W'(last_cnt) + IDX_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            lead_left <= '0;
            bit_left  <= '0;
            byte_idx  <= '0;
            shreg     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        lead_left <= lead;
                        shreg     <= dev_addr;
                        bit_left  <= 3'd7;
                        byte_idx  <= '0;
                        state     <= (lead == '0) ? ST_SHIFT : ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    lead_left <= lead_left - LEAD_W'(1);
                    if (lead_left == LEAD_W'(1)) state <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (bit_left == 3'd0) begin
                        if (byte_idx == last_idx) begin
                            state <= ST_FIN;
                        end else begin
                            shreg    <= cmd_buf[byte_idx[CNT_W-1:0]];
                            byte_idx <= byte_idx + IDX_W'(1);
                            bit_left <= 3'd7;
                        end
                    end else begin
                        shreg    <= {shreg[6:0], 1'b0};
                        bit_left <= bit_left - 3'd1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign active   = (state != ST_IDLE);
    assign fin      = (state == ST_FIN);
    assign pins.cs  = (state == ST_LEAD) || (state == ST_SHIFT);
    assign pins.stb = (state == ST_SHIFT);
    assign pins.dat = (state == ST_SHIFT) && shreg[7];

    p_stb_in_cs_r4: assert property (@(posedge clk) disable iff (rst)
        pins.stb |-> pins.cs);

    p_fin_single_r6: assert property (@(posedge clk) disable iff (rst)
        fin |=> !fin);

    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        active |=> ($stable(last_cnt) && $stable(dev_addr) && $stable(lead)));

endmodule

// File: rtl/otp_cmd_seq.sv
module otp_cmd_seq
    import otp_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 8,
    parameter int LEAD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              otp_cs,
    output logic              otp_stb,
    output logic              otp_dat
);

    localparam int CNT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic                  ctrl_en;
    logic [7:0]            dev_addr;
    logic [CNT_W-1:0]      last_cnt;
    logic [LEAD_W-1:0]     lead;
    logic [DEPTH-1:0][7:0] cmd_buf;
    logic                  seq_active;
    logic                  seq_fin;
    ser_pins_t             pins;

    otp_seq_regs #(
        .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .LEAD_W(LEAD_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .seq_active (seq_active),
        .seq_fin    (seq_fin),
        .ctrl_en    (ctrl_en),
        .dev_addr   (dev_addr),
        .last_cnt   (last_cnt),
        .lead       (lead),
        .cmd_buf    (cmd_buf)
    );

    otp_seq_shifter #(
        .DEPTH(DEPTH), .CNT_W(CNT_W), .LEAD_W(LEAD_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (ctrl_en),
        .dev_addr (dev_addr),
        .last_cnt (last_cnt),
        .lead     (lead),
        .cmd_buf  (cmd_buf),
        .active   (seq_active),
        .fin      (seq_fin),
        .pins     (pins)
    );

    assign otp_cs  = pins.cs;
    assign otp_stb = pins.stb;
    assign otp_dat = pins.dat;

endmodule

// File: tb/otp_cmd_seq_tb.sv
module otp_cmd_seq_tb;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        otp_cs, otp_stb, otp_dat;

    always #2 clk = ~clk;

    otp_cmd_seq u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .otp_cs(otp_cs), .otp_stb(otp_stb), .otp_dat(otp_dat)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // behavioural model state
    logic [15:0] m_ctrl = '0;
    int          m_cnt = 0;
    int          m_lead = 0;
    logic [7:0]  m_buf [DEPTH];
    bit          m_busy = 0;
    bit          m_done = 0;
    logic [2:0]  exp_q [$];

    initial for (int i = 0; i < DEPTH; i++) m_buf[i] = '0;

    function automatic logic [15:0] merge(input logic [15:0] c, input logic [31:0] w);
        return (c & ~w[31:16]) | (w[15:0] & w[31:16]);
    endfunction

    // per-cycle comparison of the serial pins against the model
    always @(negedge clk) begin
        if (!rst) begin
            logic [2:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 3'b000;
            n_chk++;
            if ({otp_cs, otp_stb, otp_dat} !== e) begin
                n_fail++;
                $display("FAIL R4/R5 serial pins got=%b exp=%b at %0t",
                         {otp_cs, otp_stb, otp_dat}, e, $time);
            end
        end
    end

    task automatic push_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) exp_q.push_back({2'b11, b[i]});
    endtask

    task automatic start_model();
        m_busy = 1;
        exp_q.push_back(3'b000);
        for (int i = 0; i < m_lead; i++) exp_q.push_back(3'b100);
        push_byte(m_ctrl[15:8]);
        for (int i = 0; i <= m_cnt; i++) push_byte(m_buf[i]);
        exp_q.push_back(3'b000);
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
        if (a == 16'h0304) begin
            if (d[1]) m_done = 0;
        end else if (!m_busy) begin
            if (a == 16'h0020) begin
                m_ctrl = merge(m_ctrl, d);
                if (m_ctrl[0]) start_model();
            end else if (a == 16'h0024) begin
                m_cnt = int'(merge(16'(m_cnt), d)) & (DEPTH - 1);
            end else if (a == 16'h0028) begin
                m_lead = int'(merge(16'(m_lead), d)) & 15;
            end else if (a >= 16'h1000 && a < 16'h1000 + 4*DEPTH && a[1:0] == 2'b00) begin
                m_buf[(a - 16'h1000) >> 2] = d[7:0];
            end
        end
    endtask

    task automatic rd_chk(input logic [15:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        n_chk++;
        if (reg_rdata !== e) begin
            n_fail++;
            $display("FAIL %s addr=%h got=%h exp=%h", tag, a, reg_rdata, e);
        end
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        m_busy = 0; m_ctrl[0] = 1'b0; m_done = 1;
    endtask

    task automatic chk_model(input string tag);
        rd_chk(16'h0020, {16'h0, m_ctrl}, tag);
        rd_chk(16'h0024, 32'(m_cnt), tag);
        rd_chk(16'h0028, 32'(m_lead), tag);
        rd_chk(16'h002C, {31'h0, m_busy}, tag);
        rd_chk(16'h0304, {30'h0, m_done, 1'b0}, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        chk_model("R10 reset");
        rd_chk(16'h1000, 32'h0, "R10 reset buffer");
        rd_chk(16'h0500, 32'h0, "R10 unmapped");

        // R1: masked writes
        wr(16'h0020, 32'h0000_AB00);
        rd_chk(16'h0020, 32'h0, "R1 no mask");
        wr(16'h0020, 32'hFF00_AB00);
        rd_chk(16'h0020, 32'h0000_AB00, "R1 full mask");
        wr(16'h0020, 32'h0F00_5500);
        rd_chk(16'h0020, 32'h0000_A500, "R1 partial mask");
        wr(16'h0024, 32'h0007_0005);
        wr(16'h0024, 32'h0002_0000);
        rd_chk(16'h0024, 32'h5, "R1 count mask");
        wr(16'h0024, 32'h0003_0002);
        rd_chk(16'h0024, 32'h6, "R1 count partial");
        wr(16'h0020, 32'h0000_0001);
        chk_model("R1 enable without mask");

        // R2 R3 R4 R6: error-correction disable burst, no lead
        wr(16'h0028, 32'h000F_0000);
        wr(16'h1000, 32'h0000_00FA);
        wr(16'h1004, 32'h0000_0009);
        wr(16'h0024, 32'h0007_0001);
        wr(16'h0020, 32'hFF01_0201);
        rd_chk(16'h002C, 32'h1, "R8 busy during burst");
        wait_idle();
        chk_model("R6 R8 after ecc burst");

        // R7: write-one-to-clear
        wr(16'h0304, 32'h0000_0000);
        rd_chk(16'h0304, 32'h2, "R7 zero write keeps");
        wr(16'h0304, 32'h0000_0002);
        rd_chk(16'h0304, 32'h0, "R7 one clears");

        // R3 R5: full depth with lead, then R9 writes during the burst
        for (int i = 0; i < DEPTH; i++)
            wr(16'(16'h1000 + 4*i), 32'(8'h81 ^ (i * 8'h3B)));
        wr(16'h0024, 32'h0007_0007);
        wr(16'h0028, 32'h000F_0003);
        wr(16'h0020, 32'hFF01_5A01);
        wr(16'h1000, 32'h0000_00EE);
        wr(16'h0020, 32'hFFFF_1200);
        wr(16'h0024, 32'h0007_0002);
        wr(16'h0028, 32'h000F_0000);
        chk_model("R9 writes ignored while busy");
        rd_chk(16'h1000, {24'h0, m_buf[0]}, "R9 buffer unchanged");
        wait_idle();
        chk_model("R5 R6 after long burst");
        wr(16'h0304, 32'h0000_0002);

        // R3: single command, count zero
        wr(16'h0028, 32'h000F_0000);
        wr(16'h1000, 32'h0000_0000);
        wr(16'h0024, 32'h0007_0000);
        wr(16'h0020, 32'hFF01_0201);
        wait_idle();
        chk_model("R3 single command");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule